// File: doc/BRIEF.md
# Flash Memory Command Sequencer

This block sits behind the bus-write port of a parallel NOR flash and turns the stream of write cycles into commands. Every write carries an address and an 8-bit code, marked by a one-cycle strobe. The block recognises the two-write unlock preamble, counts its way through command sequences of one to six writes, and keeps track of the operating mode that the read-path multiplexer needs. In the modes where a command is not legal, that command is ignored.

When a sequence completes, the block emits a single-cycle start pulse toward the program/erase controller. Alongside the pulse it presents the captured address and data, and for a double-word program it also presents the first word. The block has no notion of execution time. While the controller reports busy, the only write that is acted on is a suspend request, which is passed on as a pulse. A flag from the supply monitor that reports high programming voltage forces the fast-program (unlock-bypass) mode.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, `mode` is 0 (array read) and all pulse outputs are low. Mode codes: 0 array read, 1 identifier read, 2 query table, 3 bypass, 4 extra block, 5 error hold.
- R2: In array-read or extra-block mode, four writes start a program and raise `pgm_start` for one cycle: AAh at low address 555h, then 55h at 2AAh, then A0h, then the target write. The outputs `op_addr`/`op_data` show the target write. Only the low 11 address bits are compared for the unlock writes.
- R3: A write that breaks a sequence discards it without a pulse. In array-read mode the block stays in mode 0.
- R4: Unlock followed by 90h enters mode 1. In mode 1, program, erase and double-word sequences have no effect. F0h, given as one write or after the unlock pair, returns the block to mode 0.
- R5: 98h written at low address 55h enters mode 2, from mode 0 or mode 1 only. F0h then returns to the mode that was active before; every other write is ignored.
- R6: Unlock followed by 20h enters mode 3. In mode 3, A0h plus the target write gives `pgm_start`, F0h and 98h have no effect, and 90h followed by 00h returns to mode 0.
- R7: In mode 0, 50h followed by two target writes gives `dw_start`. `first_addr`/`first_data` hold the first word and `op_addr`/`op_data` the second. If the two addresses differ in any bit other than bit 0, no pulse is given and mode 5 is entered.
- R8: Unlock, 80h, unlock, 10h raises `chip_erase_start`. Unlock, 80h, unlock, 30h raises `blk_erase_sel`, with `op_addr` set to the block address.
- R9: Unlock followed by 88h enters mode 4. F0h does not leave mode 4. Unlock, 90h, 00h returns to mode 0.
- R10: In mode 5, only a one-write F0h or an unlock-then-F0h sequence has an effect, and it returns the block to mode 0.
- R11: While `vpp_high` is 1, `mode` reads 3 from the next cycle on, and the bypass exit sequence does not leave mode 3.
- R12: While `busy` is 1, every write is ignored except B0h, which raises `suspend_req` for one cycle.
- R13: Each pulse is high for exactly one cycle, in the cycle after the completing write, and at most one start pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus-write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write command/data byte |
| busy | input | 1 | Controller executing an operation |
| vpp_high | input | 1 | High programming voltage present |
| mode | output | 3 | Current mode code (see R1) |
| pgm_start | output | 1 | Single-word program start pulse |
| dw_start | output | 1 | Double-word program start pulse |
| chip_erase_start | output | 1 | Whole-array erase start pulse |
| blk_erase_sel | output | 1 | First block-erase selection pulse |
| suspend_req | output | 1 | Erase suspend request pulse |
| op_addr | output | ADDR_W | Address of the completing write |
| op_data | output | 8 | Data of the completing write |
| first_addr | output | ADDR_W | First-word address of a double-word program |
| first_data | output | 8 | First-word data of a double-word program |

## Verification
The bench targets the cases where the mode filter must throw away a sequence that is otherwise valid. A full program sequence is sent in identifier and query modes, where a missing filter would produce a stray `pgm_start`. It also checks the nested return: after entering the query table from identifier mode, one F0h must land in mode 1 and not mode 0. A design without the saved previous mode would skip a level. It confirms that F0h leaves bypass and extra-block modes untouched, and that voltage forcing overrides the bypass exit. It also checks that a double-word pair whose addresses differ at bit 1 lands in error hold without a pulse, and that the three-write reset also clears that state.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_AUTOSEL = 3'd1,
        MODE_CFI     = 3'd2,
        MODE_BYPASS  = 3'd3,
        MODE_EXTBLK  = 3'd4,
        MODE_ERRHOLD = 3'd5
    } mode_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_U1,
        PH_U2,
        PH_PGM,
        PH_X90,
        PH_E80,
        PH_EU1,
        PH_EU2,
        PH_DW1,
        PH_DW2,
        PH_BYP_PGM,
        PH_BYP_EXIT
    } phase_e;

    typedef struct packed {
        logic       unlock1;
        logic       unlock2;
        logic       cfi_key;
        logic [7:0] code;
    } token_t;

    localparam logic [7:0] CMD_RESET    = 8'hF0;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_QUERY    = 8'h98;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_BYPASS   = 8'h20;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_CHIPERS  = 8'h10;
    localparam logic [7:0] CMD_BLKERS   = 8'h30;
    localparam logic [7:0] CMD_DWORD    = 8'h50;
    localparam logic [7:0] CMD_EXTBLK   = 8'h88;
    localparam logic [7:0] CMD_ZERO     = 8'h00;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] KEY_FIRST    = 8'hAA;
    localparam logic [7:0] KEY_SECOND   = 8'h55;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
#(
    parameter int KEY_W = 11
) (
    input  logic [KEY_W-1:0] key_addr,
    input  logic [7:0]       data,
    output token_t           tok
);

    localparam logic [KEY_W-1:0] ADDR_FIRST  = KEY_W'(12'h555);
    localparam logic [KEY_W-1:0] ADDR_SECOND = KEY_W'(12'h2AA);
    localparam logic [KEY_W-1:0] ADDR_QUERY  = KEY_W'(12'h055);

    always_comb begin
        tok.code    = data;
        tok.unlock1 = (data == KEY_FIRST)  && (key_addr == ADDR_FIRST);
        tok.unlock2 = (data == KEY_SECOND) && (key_addr == ADDR_SECOND);
        tok.cfi_key = (data == CMD_QUERY)  && (key_addr == ADDR_QUERY);
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  token_t            tok,
    input  logic              busy,
    input  logic              vpp_high,
    output mode_e             mode,
    output logic              pgm_start,
    output logic              dw_start,
    output logic              chip_erase_start,
    output logic              blk_erase_sel,
    output logic              suspend_req,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic [ADDR_W-1:0] first_addr,
    output logic [7:0]        first_data
);

    typedef struct packed {
        mode_e             mode;
        mode_e             prev;
        phase_e            phase;
        logic [ADDR_W-1:0] first_addr;
        logic [7:0]        first_data;
        logic [ADDR_W-1:0] op_addr;
        logic [7:0]        op_data;
        logic              pgm;
        logic              dw;
        logic              ce;
        logic              be;
        logic              susp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pgm  = 1'b0;
        st_d.dw   = 1'b0;
        st_d.ce   = 1'b0;
        st_d.be   = 1'b0;
        st_d.susp = 1'b0;

        if (wr_valid && busy) begin
            if (tok.code == CMD_SUSPEND) st_d.susp = 1'b1;
        end else if (wr_valid) begin
            st_d.phase = PH_IDLE;
            case (st_q.mode)
                MODE_ERRHOLD: begin
                    case (st_q.phase)
                        PH_IDLE: begin
                            if (tok.code == CMD_RESET) st_d.mode = MODE_READ;
                            else if (tok.unlock1)      st_d.phase = PH_U1;
                        end
                        PH_U1: if (tok.unlock2) st_d.phase = PH_U2;
                        PH_U2: if (tok.code == CMD_RESET) st_d.mode = MODE_READ;
                        default: ;
                    endcase
                end
                MODE_CFI: begin
                    if (tok.code == CMD_RESET) st_d.mode = st_q.prev;
                end
                MODE_BYPASS: begin
                    case (st_q.phase)
                        PH_IDLE: begin
                            if (tok.code == CMD_PROGRAM)    st_d.phase = PH_BYP_PGM;
                            else if (tok.code == CMD_IDENT) st_d.phase = PH_BYP_EXIT;
                        end
                        PH_BYP_PGM: begin
                            st_d.pgm     = 1'b1;
                            st_d.op_addr = wr_addr;
                            st_d.op_data = tok.code;
                        end
                        PH_BYP_EXIT: if (tok.code == CMD_ZERO) st_d.mode = MODE_READ;
                        default: ;
                    endcase
                end
                default: begin
                    case (st_q.phase)
                        PH_IDLE: begin
                            if (tok.code == CMD_RESET) begin
                                if (st_q.mode != MODE_EXTBLK) st_d.mode = MODE_READ;
                            end else if (tok.cfi_key && st_q.mode != MODE_EXTBLK) begin
                                st_d.prev = st_q.mode;
                                st_d.mode = MODE_CFI;
                            end else if (tok.unlock1) begin
                                st_d.phase = PH_U1;
                            end else if (tok.code == CMD_DWORD && st_q.mode == MODE_READ) begin
                                st_d.phase = PH_DW1;
                            end
                        end
                        PH_U1: if (tok.unlock2) st_d.phase = PH_U2;
                        PH_U2: begin
                            case (tok.code)
                                CMD_RESET: if (st_q.mode != MODE_EXTBLK) st_d.mode = MODE_READ;
                                CMD_IDENT: begin
                                    if (st_q.mode == MODE_READ)        st_d.mode = MODE_AUTOSEL;
                                    else if (st_q.mode == MODE_EXTBLK) st_d.phase = PH_X90;
                                end
                                CMD_PROGRAM: if (st_q.mode != MODE_AUTOSEL) st_d.phase = PH_PGM;
                                CMD_BYPASS:  if (st_q.mode == MODE_READ) st_d.mode = MODE_BYPASS;
                                CMD_ERASE:   if (st_q.mode == MODE_READ) st_d.phase = PH_E80;
                                CMD_EXTBLK:  if (st_q.mode == MODE_READ) st_d.mode = MODE_EXTBLK;
                                default: ;
                            endcase
                        end
                        PH_PGM: begin
                            st_d.pgm     = 1'b1;
                            st_d.op_addr = wr_addr;
                            st_d.op_data = tok.code;
                        end
                        PH_X90: if (tok.code == CMD_ZERO) st_d.mode = MODE_READ;
                        PH_E80: if (tok.unlock1) st_d.phase = PH_EU1;
                        PH_EU1: if (tok.unlock2) st_d.phase = PH_EU2;
                        PH_EU2: begin
                            if (tok.code == CMD_CHIPERS) begin
                                st_d.ce = 1'b1;
                            end else if (tok.code == CMD_BLKERS) begin
                                st_d.be      = 1'b1;
                                st_d.op_addr = wr_addr;
                                st_d.op_data = tok.code;
                            end
                        end
                        PH_DW1: begin
                            st_d.first_addr = wr_addr;
                            st_d.first_data = tok.code;
                            st_d.phase      = PH_DW2;
                        end
                        PH_DW2: begin
                            if (wr_addr[ADDR_W-1:1] == st_q.first_addr[ADDR_W-1:1]) begin
                                st_d.dw      = 1'b1;
                                st_d.op_addr = wr_addr;
                                st_d.op_data = tok.code;
                            end else begin
                                st_d.mode = MODE_ERRHOLD;
                            end
                        end
                        default: ;
                    endcase
                end
            endcase
        end

        if (vpp_high) begin
            if (st_q.mode != MODE_BYPASS) st_d.phase = PH_IDLE;
            st_d.mode = MODE_BYPASS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode             = st_q.mode;
    assign pgm_start        = st_q.pgm;
    assign dw_start         = st_q.dw;
    assign chip_erase_start = st_q.ce;
    assign blk_erase_sel    = st_q.be;
    assign suspend_req      = st_q.susp;
    assign op_addr          = st_q.op_addr;
    assign op_data          = st_q.op_data;
    assign first_addr       = st_q.first_addr;
    assign first_data       = st_q.first_data;

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int KEY_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic              vpp_high,
    output logic [2:0]        mode,
    output logic              pgm_start,
    output logic              dw_start,
    output logic              chip_erase_start,
    output logic              blk_erase_sel,
    output logic              suspend_req,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic [ADDR_W-1:0] first_addr,
    output logic [7:0]        first_data
);

    token_t tok;
    mode_e  mode_cur;

    flash_cmd_decode #(.KEY_W(KEY_W)) i_decode (
        .key_addr (wr_addr[KEY_W-1:0]),
        .data     (wr_data),
        .tok      (tok)
    );

    flash_cmd_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_valid         (wr_valid),
        .wr_addr          (wr_addr),
        .tok              (tok),
        .busy             (busy),
        .vpp_high         (vpp_high),
        .mode             (mode_cur),
        .pgm_start        (pgm_start),
        .dw_start         (dw_start),
        .chip_erase_start (chip_erase_start),
        .blk_erase_sel    (blk_erase_sel),
        .suspend_req      (suspend_req),
        .op_addr          (op_addr),
        .op_data          (op_data),
        .first_addr       (first_addr),
        .first_data       (first_data)
    );

    assign mode = mode_cur;

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic [7:0] wr_data,
    input logic       busy,
    input logic       vpp_high,
    input logic [2:0] mode,
    input logic       pgm_start,
    input logic       dw_start,
    input logic       chip_erase_start,
    input logic       blk_erase_sel,
    input logic       suspend_req
);

    // R1: mode code stays in the defined range
    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode <= 3'd5);

    // R3: without a write or voltage forcing the mode does not move
    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_valid) && !$past(vpp_high)) |-> $stable(mode));

    // R5: leaving the query table lands in array read or identifier read
    assert_query_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd2 && mode != 3'd2 && !$past(vpp_high)) |-> (mode == 3'd0 || mode == 3'd1));

    // R10: error hold is left only toward array read
    assert_errhold_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd5 && mode != 3'd5 && !$past(vpp_high)) |-> mode == 3'd0);

    // R11: high programming voltage forces bypass mode
    assert_vpp_force_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vpp_high) |-> mode == 3'd3);

    // R12: start pulses need an accepted write in the cycle before
    assert_start_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_start || dw_start || chip_erase_start || blk_erase_sel) |-> $past(wr_valid && !busy));

    // R12: suspend pulses come only from a B0h write while busy
    assert_suspend_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> $past(wr_valid && busy && wr_data == 8'hB0));

    // R13: never two start pulses together
    assert_pulse_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_start, dw_start, chip_erase_start, blk_erase_sel}));

    // R13: program pulse lasts one cycle
    assert_pgm_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_start |=> !pgm_start);

endmodule

bind flash_cmd_fsm flash_cmd_checker i_chk (.*);

// File: tb/test_flash_cmd_fsm.sv
module test_flash_cmd_fsm;

    localparam int ADDR_W = 22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              busy = 1'b0;
    logic              vpp_high = 1'b0;
    logic [2:0]        mode;
    logic              pgm_start, dw_start, chip_erase_start, blk_erase_sel, suspend_req;
    logic [ADDR_W-1:0] op_addr, first_addr;
    logic [7:0]        op_data, first_data;

    int n_chk = 0;
    int n_fail = 0;
    int pgm_n = 0, dw_n = 0, ce_n = 0, be_n = 0, sus_n = 0;
    bit done = 1'b0;

    flash_cmd_fsm #(.ADDR_W(ADDR_W)) i_flash_cmd_fsm (.*);

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (pgm_start)        pgm_n++;
        if (dw_start)         dw_n++;
        if (chip_erase_start) ce_n++;
        if (blk_erase_sel)    be_n++;
        if (suspend_req)      sus_n++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock();
        wr(22'h555, 8'hAA);
        wr(22'h2AA, 8'h55);
    endtask

    task automatic program_seq(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        unlock();
        wr(22'h555, 8'hA0);
        wr(a, d);
    endtask

    task automatic t_reset();
        chk("R1 reset mode", 32'(mode), 32'd0);
        chk("R1 reset pulses", 32'({pgm_start, dw_start, chip_erase_start, blk_erase_sel, suspend_req}), 32'd0);
    endtask

    task automatic t_program();
        int p0 = pgm_n;
        program_seq(22'h12345, 8'h5A);
        chk("R2 pgm_start high", 32'(pgm_start), 32'd1);
        chk("R2 op_addr", 32'(op_addr), 32'h12345);
        chk("R2 op_data", 32'(op_data), 32'h5A);
        idle(1);
        chk("R13 pgm_start one cycle", 32'(pgm_start), 32'd0);
        chk("R13 pgm pulse count", 32'(pgm_n - p0), 32'd1);
        chk("R2 mode stays read", 32'(mode), 32'd0);
    endtask

    task automatic t_break();
        int p0 = pgm_n;
        wr(22'h555, 8'hAA);
        wr(22'h123, 8'h55);
        wr(22'h555, 8'hA0);
        wr(22'h000, 8'h33);
        unlock();
        wr(22'h555, 8'h77);
        wr(22'h555, 8'hA0);
        wr(22'h004, 8'h44);
        idle(1);
        chk("R3 no pulse after broken sequence", 32'(pgm_n - p0), 32'd0);
        chk("R3 mode read", 32'(mode), 32'd0);
    endtask

    task automatic t_autosel();
        int p0 = pgm_n;
        int d0 = dw_n;
        unlock();
        wr(22'h555, 8'h90);
        chk("R4 enter identifier mode", 32'(mode), 32'd1);
        program_seq(22'h00010, 8'h01);
        wr(22'h0, 8'h50);
        wr(22'h20, 8'h01);
        wr(22'h21, 8'h02);
        idle(1);
        chk("R4 program ignored", 32'(pgm_n - p0), 32'd0);
        chk("R4 dword ignored", 32'(dw_n - d0), 32'd0);
        chk("R4 mode held", 32'(mode), 32'd1);
        wr(22'h0, 8'hF0);
        chk("R4 reset to read", 32'(mode), 32'd0);
    endtask

    task automatic t_cfi();
        int p0 = pgm_n;
        wr(22'h55, 8'h98);
        chk("R5 query from read", 32'(mode), 32'd2);
        program_seq(22'h30, 8'h03);
        idle(1);
        chk("R5 program ignored in query", 32'(pgm_n - p0), 32'd0);
        chk("R5 query held", 32'(mode), 32'd2);
        wr(22'h0, 8'hF0);
        chk("R5 return to read", 32'(mode), 32'd0);
        unlock();
        wr(22'h555, 8'h90);
        wr(22'h55, 8'h98);
        chk("R5 query from identifier", 32'(mode), 32'd2);
        wr(22'h0, 8'hF0);
        chk("R5 return to identifier", 32'(mode), 32'd1);
        wr(22'h0, 8'hF0);
        chk("R5 second reset to read", 32'(mode), 32'd0);
    endtask

    task automatic t_bypass();
        int p0 = pgm_n;
        unlock();
        wr(22'h555, 8'h20);
        chk("R6 enter bypass", 32'(mode), 32'd3);
        wr(22'h0, 8'hA0);
        wr(22'h777, 8'h11);
        chk("R6 bypass op_addr", 32'(op_addr), 32'h777);
        chk("R6 bypass op_data", 32'(op_data), 32'h11);
        idle(1);
        chk("R6 bypass pulse count", 32'(pgm_n - p0), 32'd1);
        wr(22'h0, 8'hF0);
        chk("R6 reset keeps bypass", 32'(mode), 32'd3);
        wr(22'h55, 8'h98);
        chk("R6 query refused in bypass", 32'(mode), 32'd3);
        wr(22'h0, 8'h90);
        wr(22'h0, 8'h00);
        chk("R6 bypass exit", 32'(mode), 32'd0);
    endtask

    task automatic t_dword();
        int d0 = dw_n;
        wr(22'h0, 8'h50);
        wr(22'h100, 8'hAB);
        wr(22'h101, 8'hCD);
        chk("R7 dw_start high", 32'(dw_start), 32'd1);
        chk("R7 first_addr", 32'(first_addr), 32'h100);
        chk("R7 first_data", 32'(first_data), 32'hAB);
        chk("R7 second op_addr", 32'(op_addr), 32'h101);
        chk("R7 second op_data", 32'(op_data), 32'hCD);
        wr(22'h0, 8'h50);
        wr(22'h200, 8'h01);
        wr(22'h202, 8'h02);
        idle(1);
        chk("R7 mismatched pair no pulse", 32'(dw_n - d0), 32'd1);
        chk("R7 mismatched pair error hold", 32'(mode), 32'd5);
    endtask

    task automatic t_errhold();
        int p0 = pgm_n;
        program_seq(22'h40, 8'h04);
        wr(22'h55, 8'h98);
        idle(1);
        chk("R10 program ignored in error hold", 32'(pgm_n - p0), 32'd0);
        chk("R10 error hold kept", 32'(mode), 32'd5);
        wr(22'h0, 8'hF0);
        chk("R10 one-write reset clears", 32'(mode), 32'd0);
        wr(22'h0, 8'h50);
        wr(22'h300, 8'h01);
        wr(22'h700, 8'h02);
        chk("R10 re-enter error hold", 32'(mode), 32'd5);
        unlock();
        wr(22'h555, 8'hF0);
        chk("R10 three-write reset clears", 32'(mode), 32'd0);
    endtask

    task automatic t_erase();
        int c0 = ce_n;
        int b0 = be_n;
        unlock();
        wr(22'h555, 8'h80);
        unlock();
        wr(22'h555, 8'h10);
        chk("R8 chip erase pulse", 32'(chip_erase_start), 32'd1);
        unlock();
        wr(22'h555, 8'h80);
        unlock();
        wr(22'h3F000, 8'h30);
        chk("R8 block select pulse", 32'(blk_erase_sel), 32'd1);
        chk("R8 block address", 32'(op_addr), 32'h3F000);
        idle(1);
        chk("R13 chip erase count", 32'(ce_n - c0), 32'd1);
        chk("R13 block select count", 32'(be_n - b0), 32'd1);
    endtask

    task automatic t_ext();
        int p0 = pgm_n;
        unlock();
        wr(22'h555, 8'h88);
        chk("R9 enter extra block", 32'(mode), 32'd4);
        wr(22'h0, 8'hF0);
        chk("R9 reset keeps extra block", 32'(mode), 32'd4);
        program_seq(22'h50, 8'h55);
        idle(1);
        chk("R2 program in extra block", 32'(pgm_n - p0), 32'd1);
        unlock();
        wr(22'h555, 8'h90);
        chk("R9 still extra block before 00h", 32'(mode), 32'd4);
        wr(22'h0, 8'h00);
        chk("R9 exit extra block", 32'(mode), 32'd0);
    endtask

    task automatic t_vpp();
        @(negedge clk);
        vpp_high = 1'b1;
        idle(1);
        chk("R11 forced bypass", 32'(mode), 32'd3);
        wr(22'h0, 8'h90);
        wr(22'h0, 8'h00);
        idle(1);
        chk("R11 exit overridden", 32'(mode), 32'd3);
        vpp_high = 1'b0;
        wr(22'h0, 8'h90);
        wr(22'h0, 8'h00);
        chk("R11 exit after voltage drop", 32'(mode), 32'd0);
    endtask

    task automatic t_busy();
        int p0 = pgm_n;
        int s0 = sus_n;
        busy = 1'b1;
        program_seq(22'h60, 8'h06);
        unlock();
        wr(22'h555, 8'h90);
        wr(22'h0, 8'hB0);
        chk("R12 suspend pulse", 32'(suspend_req), 32'd1);
        idle(1);
        chk("R12 suspend one cycle", 32'(suspend_req), 32'd0);
        chk("R12 program ignored while busy", 32'(pgm_n - p0), 32'd0);
        chk("R12 suspend count", 32'(sus_n - s0), 32'd1);
        chk("R12 mode unchanged while busy", 32'(mode), 32'd0);
        busy = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_program();
        t_break();
        t_autosel();
        t_cfi();
        t_bypass();
        t_dword();
        t_errhold();
        t_erase();
        t_ext();
        t_vpp();
        t_busy();
        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule